// File: doc/BRIEF.md
# Programmable 3x4 Colour-Space Converter

This unit converts a stream of three-component pixels from one colour space into another with a programmable 3x4 signed fixed-point matrix. Each output channel is the sum of the three input components, each multiplied by its own coefficient, plus a per-channel constant. The sum is then shifted down by the fraction width and clipped to the 8-bit component range. Software loads the twelve matrix words and the enable bit through a single-cycle register write port. A combinational read port returns the stored values.

All coefficients are 32-bit two's-complement numbers with 10 fractional bits. Constants are expressed at full 8-bit pixel scale. Software folds the half-LSB rounding term (0x200) into each constant before writing it, so the datapath itself only truncates. Input orderings such as Y-U-V and Y-V-U are handled purely by swapping coefficient columns in software. When the enable bit is clear, pixels pass through unchanged with the same latency, so stream order is kept.

Pixels travel through a three-stage pipeline under valid/ready flow control. The whole pipeline stalls while the downstream ready is low. Each pixel uses the matrix and enable setting that were in force on the clock edge that accepted it.

Top module: `csc_matrix_unit`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero, the enable bit is clear, and `out_valid` is low.
- R2: Offset 0x00 is the control word: bit 0 is the enable, and the other bits read as zero. Matrix word i (0..11) sits at offset 0x10 + 4*i and reads back as written. Words 4j, 4j+1 and 4j+2 weight input components 0, 1 and 2 for output channel j. Word 4j+3 is the constant for channel j.
- R3: Reading any other offset (including offsets that are not multiples of four) returns zero. Writing any other offset changes no register.
- R4: With the enable bit set, output channel j equals floor((w0*c0 + w1*c1 + w2*c2 + k) / 1024), computed in signed arithmetic without overflow. No rounding is added beyond the constant.
- R5: A converted result below 0 is output as 0, and a result above 255 is output as 255, even for extreme 32-bit coefficients.
- R6: With the enable bit clear, each output pixel equals the corresponding input pixel.
- R7: An accepted pixel appears on the output after the third rising edge, counting the accepting edge as the first, when `out_ready` stays high. This holds in both converted and bypass mode.
- R8: `in_ready` follows `out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_pix` hold. No pixel is lost, duplicated or reordered.
- R9: A write to the matrix or the enable bit affects only pixels accepted on a later edge. Pixels already in the pipeline keep the settings they were accepted with.
- R10: Pixel component n occupies bits [8n+7:8n] of `in_pix`, and output channel j occupies bits [8j+7:8j] of `out_pix`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset for register write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high together with `in_valid` |
| in_pix | input | 24 | Input pixel, three 8-bit components |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream ready; low stalls the whole pipeline |
| out_pix | output | 24 | Output pixel, three 8-bit channels |

## Verification
The hardest case to reach from the ports is a register write that commits on the same edge that accepts a pixel, while older pixels are still in flight and the downstream ready is toggling. The bench forks a register writer against a back-to-back pixel driver. Its reference model records each expected result at the accepting edge, using the model's register copy as it stands at that moment. A pseudo-random ready pattern then exercises backpressure across converted and bypassed pixels, including an enable flip in mid-stream.

// File: rtl/csc_pkg.sv
// Shared constants for the colour-space converter: channel count,
// words per matrix row and the fixed register offsets.
// Assumes three components per pixel and a byte-addressed register space.
package csc_pkg;
    localparam int NUM_CH      = 3;                  // components per pixel
    localparam int ROW_TERMS   = NUM_CH + 1;         // weights plus constant per row
    localparam int NUM_COEF    = NUM_CH * ROW_TERMS; // matrix words
    localparam int CTRL_OFS    = 0;                  // control word offset
    localparam int COEF_BASE   = 16;                 // first matrix word offset
    localparam int WORD_STRIDE = 4;                  // bytes per matrix word
endpackage

// File: rtl/csc_regfile.sv
// Register file for the converter: one enable bit and NUM_COEF signed
// matrix words, with a single-cycle write port and a combinational read.
// Assumes word-aligned offsets; anything unmapped reads zero and ignores writes.
module csc_regfile
    import csc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int COEF_W = 32
)(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [COEF_W-1:0]                wdata,
    output logic [COEF_W-1:0]                rdata,
    output logic                             enable_o,
    output logic [NUM_COEF-1:0][COEF_W-1:0]  coef_o
);
    localparam int IDX_W    = $clog2(NUM_COEF);
    localparam int COEF_END = COEF_BASE + WORD_STRIDE * NUM_COEF;

    logic                            en_q;
    logic [NUM_COEF-1:0][COEF_W-1:0] coef_q;
    logic                            ctrl_hit;
    logic                            coef_hit;
    logic [ADDR_W-1:0]               offs;
    logic [IDX_W-1:0]                idx;

    // Decode the offset into control hit, matrix hit and word index (R2, R3)
    always_comb begin
        ctrl_hit = (int'(addr) == CTRL_OFS);
        coef_hit = (int'(addr) >= COEF_BASE) && (int'(addr) < COEF_END)
                   && (addr[1:0] == 2'b00);
        offs     = addr - ADDR_W'(COEF_BASE);
        idx      = IDX_W'(offs >> 2);
    end

    // Store writes to mapped registers; reset clears everything (R1)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            coef_q <= '0;
        end else if (wr_en) begin
            if (ctrl_hit) begin
                en_q <= wdata[0];
            end else if (coef_hit) begin
                coef_q[idx] <= wdata;
            end
        end
    end

    // Read mux: control bit, matrix word, or zero for unmapped offsets
    always_comb begin
        if (ctrl_hit) begin
            rdata = {{(COEF_W-1){1'b0}}, en_q};
        end else if (coef_hit) begin
            rdata = coef_q[idx];
        end else begin
            rdata = '0;
        end
    end

    assign enable_o = en_q;
    assign coef_o   = coef_q;

    // R2: a control write lands its bit 0 in the enable on the next cycle
    p_ctrl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(addr) == CTRL_OFS) |=> (enable_o == $past(wdata[0])));

    // R3: a write to an unmapped offset leaves all state untouched
    p_stray_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ctrl_hit && !coef_hit) |=> ($stable(coef_q) && $stable(en_q)));
endmodule

// File: rtl/csc_row_mac.sv
// One matrix row: stage 1 registers the three weighted products and the
// sign-extended constant, stage 2 registers their full-width sum.
// Assumes unsigned components; widths are chosen so no sum can overflow.
module csc_row_mac
    import csc_pkg::*;
#(
    parameter int COMP_W = 8,
    parameter int COEF_W = 32,
    localparam int PROD_W = COEF_W + COMP_W + 1,
    localparam int SUM_W  = PROD_W + 2
)(
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               adv,
    input  logic [NUM_CH-1:0][COMP_W-1:0]      comp_i,
    input  logic [ROW_TERMS-1:0][COEF_W-1:0]   row_i,
    output logic signed [SUM_W-1:0]            sum_o
);
    logic signed [PROD_W-1:0] w_ext  [NUM_CH];
    logic signed [PROD_W-1:0] c_ext  [NUM_CH];
    logic signed [PROD_W-1:0] prod_d [NUM_CH];
    logic signed [PROD_W-1:0] prod_q [NUM_CH];
    logic signed [PROD_W-1:0] k_d;
    logic signed [PROD_W-1:0] k_q;
    logic signed [SUM_W-1:0]  acc;
    logic signed [SUM_W-1:0]  sum_q;

    // Form the signed products of each weight with its zero-extended component
    always_comb begin
        for (int j = 0; j < NUM_CH; j++) begin
            w_ext[j]  = PROD_W'($signed(row_i[j]));
            c_ext[j]  = PROD_W'({1'b0, comp_i[j]});
            prod_d[j] = w_ext[j] * c_ext[j];
        end
        k_d = PROD_W'($signed(row_i[NUM_CH]));
    end

    // Stage 1: capture products and constant with the weights of the accepting edge (R9)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < NUM_CH; j++) prod_q[j] <= '0;
            k_q <= '0;
        end else if (adv) begin
            for (int j = 0; j < NUM_CH; j++) prod_q[j] <= prod_d[j];
            k_q <= k_d;
        end
    end

    // Add the three products and the constant at full width (R4)
    always_comb begin
        acc = SUM_W'(k_q);
        for (int j = 0; j < NUM_CH; j++) acc = acc + SUM_W'(prod_q[j]);
    end

    // Stage 2: register the row sum
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else if (adv) begin
            sum_q <= acc;
        end
    end

    assign sum_o = sum_q;

    // R8: a stalled pipeline keeps the row sum
    p_sum_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(sum_q));
endmodule

// File: rtl/csc_clamp.sv
// Drops the fraction bits of a row sum by arithmetic shift (truncation
// toward minus infinity) and saturates the result to the component range.
// Assumes rounding has already been folded into the constant by software.
module csc_clamp #(
    parameter int COMP_W = 8,
    parameter int SUM_W  = 43,
    parameter int FRAC_W = 10
)(
    input  logic signed [SUM_W-1:0] sum_i,
    output logic [COMP_W-1:0]       comp_o
);
    localparam int SH_W  = SUM_W - FRAC_W;
    localparam int C_MAX = (1 << COMP_W) - 1;

    logic signed [SH_W-1:0] shifted;

    assign shifted = SH_W'(sum_i >>> FRAC_W);

    // Saturate to 0..C_MAX (R5)
    always_comb begin
        if (shifted < 0) begin
            comp_o = '0;
        end else if (shifted > $signed(SH_W'(C_MAX))) begin
            comp_o = '1;
        end else begin
            comp_o = shifted[COMP_W-1:0];
        end
    end
endmodule

// File: rtl/csc_matrix_unit.sv
// Top of the colour-space converter: register file, three row MACs, clamps
// and a three-stage valid pipeline with a bypass path.
// Assumes the whole pipeline stalls on downstream ready; in_ready mirrors it.
module csc_matrix_unit
    import csc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int COMP_W = 8,
    parameter int COEF_W = 32,
    parameter int FRAC_W = 10
)(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_wr,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [COEF_W-1:0]        reg_wdata,
    output logic [COEF_W-1:0]        reg_rdata,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [NUM_CH*COMP_W-1:0] in_pix,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [NUM_CH*COMP_W-1:0] out_pix
);
    localparam int PIX_W  = NUM_CH * COMP_W;
    localparam int PROD_W = COEF_W + COMP_W + 1;
    localparam int SUM_W  = PROD_W + 2;

    logic                            adv;
    logic                            en;
    logic [NUM_COEF-1:0][COEF_W-1:0] coef;
    logic [NUM_CH-1:0][COMP_W-1:0]   in_comp;
    logic signed [SUM_W-1:0]         row_sum [NUM_CH];
    logic [NUM_CH-1:0][COMP_W-1:0]   conv;
    logic                            s1_valid, s2_valid, s3_valid;
    logic                            s1_en, s2_en;
    logic [PIX_W-1:0]                s1_pix, s2_pix, s3_pix;

    // Whole-pipeline advance follows downstream ready (R8)
    assign adv      = out_ready;
    assign in_ready = out_ready;
    assign in_comp  = in_pix;   // component n at bits [8n+7:8n] (R10)

    csc_regfile #(.ADDR_W(ADDR_W), .COEF_W(COEF_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .enable_o (en),
        .coef_o   (coef)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        csc_row_mac #(.COMP_W(COMP_W), .COEF_W(COEF_W)) u_mac (
            .clk    (clk),
            .rst_n  (rst_n),
            .adv    (adv),
            .comp_i (in_comp),
            .row_i  (coef[ch*ROW_TERMS +: ROW_TERMS]),
            .sum_o  (row_sum[ch])
        );

        csc_clamp #(.COMP_W(COMP_W), .SUM_W(SUM_W), .FRAC_W(FRAC_W)) u_clamp (
            .sum_i  (row_sum[ch]),
            .comp_o (conv[ch])
        );

        // R5: a negative row sum reaches the output as zero
        p_clamp_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (adv && s2_valid && s2_en && row_sum[ch] < 0)
            |=> (out_pix[ch*COMP_W +: COMP_W] == '0));
    end

    // Valid, enable and raw pixel ride alongside the row MACs; stage 3 picks the result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s2_valid <= 1'b0;
            s3_valid <= 1'b0;
            s1_en    <= 1'b0;
            s2_en    <= 1'b0;
            s1_pix   <= '0;
            s2_pix   <= '0;
            s3_pix   <= '0;
        end else if (adv) begin
            s1_valid <= in_valid;
            s1_en    <= en;
            s1_pix   <= in_pix;
            s2_valid <= s1_valid;
            s2_en    <= s1_en;
            s2_pix   <= s1_pix;
            s3_valid <= s2_valid;
            s3_pix   <= s2_en ? conv : s2_pix;
        end
    end

    assign out_valid = s3_valid;
    assign out_pix   = s3_pix;

    // R8: backpressure holds the presented pixel
    p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)));

    // R6: a bypassed pixel leaves stage 2 unchanged
    p_bypass_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && s2_valid && !s2_en) |=> (out_pix == $past(s2_pix)));

    // R7: a valid pixel in stage 2 is presented after one more advancing edge
    p_valid_chain_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && s2_valid) |=> out_valid);
endmodule

// File: tb/csc_matrix_unit_test.sv
// Scoreboard bench: the driver queues model results at each accepting edge,
// the monitor compares them against the design output in order.
module csc_matrix_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [23:0] in_pix = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [23:0] out_pix;

    int          n_checks = 0;
    int          n_fail = 0;
    longint      model_c [12];
    bit          model_en = 1'b0;
    logic [23:0] exp_q [$];
    string       tag_q [$];
    bit          stall_on = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    bit          hold_pend = 1'b0;
    logic [23:0] held_pix = '0;

    always #4 clk = ~clk;   // 125 MHz

    csc_matrix_unit uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
        .in_ready(in_ready), .in_pix(in_pix), .out_valid(out_valid),
        .out_ready(out_ready), .out_pix(out_pix)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Reference model per R4, R5, R6 and R10
    function automatic logic [23:0] model_pix(input logic [23:0] p);
        logic [23:0] r;
        if (!model_en) return p;
        for (int ch = 0; ch < 3; ch++) begin
            longint acc = model_c[4*ch+3];
            longint v;
            for (int n = 0; n < 3; n++)
                acc += model_c[4*ch+n] * longint'(p[8*n +: 8]);
            v = acc >>> 10;
            if (v < 0) r[8*ch +: 8] = 8'd0;
            else if (v > 255) r[8*ch +: 8] = 8'd255;
            else r[8*ch +: 8] = v[7:0];
        end
        return r;
    endfunction

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == 8'h00) model_en = d[0];
        else if (a >= 8'h10 && a < 8'h40 && a[1:0] == 2'b00)
            model_c[(a - 8'h10) >> 2] = longint'($signed(d));
    endtask

    task automatic reg_check(input logic [7:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, e);
    endtask

    task automatic load_matrix(input logic [31:0] m [12]);
        for (int i = 0; i < 12; i++) reg_write(8'h10 + 8'(4*i), m[i]);
    endtask

    task automatic send(input logic [23:0] p, input string tag);
        @(negedge clk);
        in_valid = 1'b1; in_pix = p;
        forever begin
            @(posedge clk);
            if (in_ready) break;
        end
        exp_q.push_back(model_pix(p));
        tag_q.push_back(tag);
        #1 in_valid = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 2000 && exp_q.size() != 0; i++) @(negedge clk);
        chk("R8 drain count", 32'(exp_q.size()), 32'd0);
    endtask

    // Downstream ready: always high, or pseudo-random while stalling
    always begin
        @(posedge clk);
        #2;
        out_ready = stall_on ? lfsr[0] : 1'b1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end

    // Monitor: hold check under backpressure and in-order scoreboard compare
    always @(negedge clk) begin
        if (!rst_n) begin
            hold_pend = 1'b0;
        end else begin
            if (hold_pend) begin
                chk("R8 held valid", 32'(out_valid), 32'd1);
                chk("R8 held pixel", 32'(out_pix), 32'(held_pix));
            end
            hold_pend = out_valid && !out_ready;
            held_pix  = out_pix;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    n_checks++; n_fail++;
                    $display("FAIL R7: actual extra output %h expected none", out_pix);
                end else begin
                    logic [23:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(t, 32'(out_pix), 32'(e));
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 12; i++) model_c[i] = 0;
        repeat (3) @(posedge clk);
        // R1: reset state
        @(negedge clk);
        chk("R1 out_valid in reset", 32'(out_valid), 32'd0);
        reg_check(8'h00, 32'd0, "R1 ctrl reset");
        reg_check(8'h10, 32'd0, "R1 word0 reset");
        reg_check(8'h24, 32'd0, "R1 word5 reset");
        reg_check(8'h3C, 32'd0, "R1 word11 reset");
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R7: latency in bypass mode, then R6 bypass stream
        send(24'hC0FFEE, "R6 bypass first");
        @(negedge clk); chk("R7 bypass edge1", 32'(out_valid), 32'd0);
        @(negedge clk); chk("R7 bypass edge2", 32'(out_valid), 32'd0);
        @(negedge clk); chk("R7 bypass edge3", 32'(out_valid), 32'd1);
        send(24'h000000, "R6 bypass zero");
        send(24'hFFFFFF, "R6 bypass ones");
        send(24'h12AB80, "R6 bypass mixed");
        drain();

        // R2: register map and readback
        for (int i = 0; i < 12; i++) reg_write(8'h10 + 8'(4*i), 32'h8000_1000 + 32'(i * 32'h0103_0507));
        for (int i = 0; i < 12; i++)
            reg_check(8'h10 + 8'(4*i), 32'h8000_1000 + 32'(i * 32'h0103_0507), "R2 word readback");
        reg_write(8'h00, 32'hFFFF_FFFE);
        reg_check(8'h00, 32'd0, "R2 ctrl bit0 clear");
        reg_write(8'h00, 32'hFFFF_FFFF);
        reg_check(8'h00, 32'd1, "R2 ctrl only bit0");
        reg_write(8'h00, 32'd0);

        // R3: unmapped offsets
        reg_write(8'h04, 32'hDEADBEEF);
        reg_write(8'h0C, 32'hDEADBEEF);
        reg_write(8'h11, 32'hDEADBEEF);
        reg_write(8'h40, 32'hDEADBEEF);
        reg_write(8'hFC, 32'hDEADBEEF);
        reg_check(8'h04, 32'd0, "R3 read 0x04");
        reg_check(8'h11, 32'd0, "R3 read 0x11");
        reg_check(8'h40, 32'd0, "R3 read 0x40");
        reg_check(8'h10, 32'h8000_1000, "R3 word0 untouched");
        reg_check(8'h3C, 32'h8000_1000 + 32'(11 * 32'h0103_0507), "R3 word11 untouched");
        reg_check(8'h00, 32'd0, "R3 ctrl untouched");

        // R4: identity matrix with half-LSB constants
        load_matrix('{32'h400, 0, 0, 32'h200, 0, 32'h400, 0, 32'h200, 0, 0, 32'h400, 32'h200});
        reg_write(8'h00, 32'd1);
        send(24'h102030, "R4 identity");
        send(24'hFF00FF, "R4 identity extremes");
        // R10: permutation proves component and channel positions
        load_matrix('{0, 0, 32'h400, 32'h200, 32'h400, 0, 0, 32'h200, 0, 32'h400, 0, 32'h200});
        send(24'h030201, "R10 permuted fields");
        send(24'hA5C35A, "R10 permuted fields 2");
        // R4: truncation, no internal rounding (0.5 * x)
        load_matrix('{32'h200, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0});
        send(24'h000001, "R4 truncate 0.5");
        send(24'h000003, "R4 truncate 1.5");
        send(24'h0000FF, "R4 truncate 127.5");
        // R5: saturation at both ends, including extreme weights
        load_matrix('{32'h800, 0, 0, 0, 0, 0, 0, 32'hFFFF_0000, 0, 0, 32'h7FFF_FFFF, 0});
        send(24'hFF00C8, "R5 saturate high/low");
        load_matrix('{32'h8000_0000, 0, 0, 0, 0, 32'h7FFF_FFFF, 0, 0, 0, 0, 0, 32'h7FFF_FFFF});
        send(24'hFFFFFF, "R5 extreme weights");
        // R4: colour matrices for both component orderings
        load_matrix('{32'h4A8, 0, 32'h662, 32'hFFFC845A + 32'h200,
                      32'h4A8, 32'hFFFFFE6F, 32'hFFFFFCBF, 32'h00021DF4 + 32'h200,
                      32'h4A8, 32'h813, 0, 32'hFFFBAC4A + 32'h200});
        send(24'h808010, "R4 colour black");
        send(24'h8080EB, "R4 colour white");
        send(24'hF05A51, "R4 colour red");
        drain();
        load_matrix('{32'h4A8, 32'h662, 0, 32'hFFFC845A + 32'h200,
                      32'h4A8, 32'hFFFFFCBF, 32'hFFFFFE6F, 32'h00021DF4 + 32'h200,
                      32'h4A8, 0, 32'h813, 32'hFFFBAC4A + 32'h200});
        send(24'h5AF051, "R4 swapped order red");
        send(24'h1029A8, "R4 swapped order mixed");
        drain();

        // R9: constant rewritten while pixels are in flight
        fork
            begin
                for (int i = 0; i < 5; i++) send(24'h406080 + 24'(i), "R9 in-flight write");
            end
            begin
                @(negedge clk); @(negedge clk);
                reg_write(8'h1C, 32'h0003_0200);
            end
        join
        drain();

        // R8: random backpressure with an enable flip mid-stream (R9, R6)
        stall_on = 1'b1;
        fork
            begin
                for (int i = 0; i < 40; i++)
                    send(24'(i * 32'h0B1D07 + 32'h030201), "R8 stalled stream");
            end
            begin
                repeat (30) @(negedge clk);
                reg_write(8'h00, 32'd0);
                repeat (20) @(negedge clk);
                reg_write(8'h00, 32'd1);
            end
        join
        drain();
        stall_on = 1'b0;
        repeat (4) @(negedge clk);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule